// File: doc/BRIEF.md
# Table-Driven Quad Serial Flash Sequencer

This block runs serial flash transactions that software describes as short programs instead of fixed command shapes. A writable table holds sixteen sequences, each made of four 32-bit words, and every word carries two 16-bit instructions. A single trigger write names a sequence and a byte count. The engine then pulls chip select low, walks the sequence slot by slot, and drives the serial clock and up to four data lines. Command, mode and address bytes go out, dummy cycles are inserted, and data bytes are written or read.

Write data comes in on a valid/ready stream and read data leaves on another. A byte moves on a stream only in a cycle where valid and ready are both high. The engine does not start shifting a write byte until it has accepted that byte. It holds a finished read byte on the output stream, with its data steady, until the consumer takes it. While it waits on either stream the serial clock stays low, so a slow producer or consumer only stretches the transaction and loses no bits. Control (table write, trigger, address value) and status (busy) are plain pins.

Top module: `flash_seq_engine`

## Requirements
- R1: During and right after reset, cs_n is 1, sclk is 0, busy is 0, io_oe is 0, tx_ready is 0 and rx_valid is 0.
- R2: An instruction is 16 bits: opcode in bits 15:10, line code in bits 9:8, operand in bits 7:0. Bits 15:0 of a word hold the earlier slot and bits 31:16 the later one. The word of sequence s at position w sits at table byte address s*16 + w*4, and slots run in order 0 to 7.
- R3: The command opcode (1) and the mode opcode (4) send their operand MSB first on 2^code lines, one line on IO0, two on IO1:IO0 and four on IO3:IO0, with the upper line carrying the more significant bit. io_oe is high on exactly those lines while they shift.
- R4: The address opcode (2) sends the lowest N bits of addr_value MSB first, where N is the operand (24 or 32; values above 32 count as 32), on 2^code lines.
- R5: The dummy opcode (3) produces as many serial clock cycles as its operand, capped at 64, with io_oe at 0 throughout.
- R6: The write opcode (8) accepts exactly the triggered byte count from the tx stream and sends each byte MSB first. With a count of 0 it is skipped. No clock pulse is produced while a byte is awaited.
- R7: The read opcode (7) returns exactly the triggered byte count on the rx stream. One-line reads sample IO1; two- and four-line reads sample IO1:IO0 and IO3:IO0. With a count of 0 it is skipped. An offered byte is held, with rx_data stable, until rx_ready is high.
- R8: sclk runs at half the system clock and idles low. Each high phase lasts one system clock. io_out never changes across a rising sclk edge, and input is captured at the system clock edge that ends the high phase.
- R9: A trigger word carries the byte count in bits 15:0 and the sequence index in bits 27:24. busy goes to 1 on the next edge. A trigger that arrives while busy is 1 is ignored.
- R10: cs_n is low from the trigger until the sequence ends, either at a stop opcode (0) or after slot 7. busy falls together with cs_n rising. Opcodes outside the list above are skipped without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Instruction table write strobe |
| tbl_addr | input | 8 | Table byte address (word aligned) |
| tbl_wdata | input | 32 | Table write word |
| trig_we | input | 1 | Trigger strobe |
| trig_word | input | 32 | Trigger word: count and sequence index |
| addr_value | input | 32 | Flash address sent by the address opcode |
| busy | output | 1 | Sequence in progress |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |
| tx_valid | input | 1 | Write stream byte valid |
| tx_ready | output | 1 | Write stream ready |
| tx_data | input | 8 | Write stream byte |
| rx_valid | output | 1 | Read stream byte valid |
| rx_ready | input | 1 | Read stream ready |
| rx_data | output | 8 | Read stream byte |

## Verification
The main function is tried with a set of transaction shapes. These are a bare command, a one-line read with no address, a one-line page-program style write, dual and quad reads with 24- and 32-bit addresses and dummy gaps, a quad write, and a sequence whose command itself runs on two lines. Checking the bits seen on each line against the line code tells lane ordering apart from bit ordering. Checking the count of clock pulses tells correct cycle budgets apart from off-by-one counters. The tx and rx streams are throttled on different rhythms, so lost, repeated or early-shifted bytes show up as wrong data or wrong counts. Directed cases cover the dummy cap, a sequence that runs out of slots with no stop, unknown opcodes, a zero byte count, a stop in slot 0 and a trigger issued while busy.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [5:0] OPC_STOP  = 6'd0;
  localparam logic [5:0] OPC_CMD   = 6'd1;
  localparam logic [5:0] OPC_ADDR  = 6'd2;
  localparam logic [5:0] OPC_DUMMY = 6'd3;
  localparam logic [5:0] OPC_MODE  = 6'd4;
  localparam logic [5:0] OPC_READ  = 6'd7;
  localparam logic [5:0] OPC_WRITE = 6'd8;

  localparam int DUMMY_CAP = 64;
  localparam int ADDR_CAP  = 32;

  typedef struct packed {
    logic [5:0] opc;
    logic [1:0] pad;
    logic [7:0] opnd;
  } instr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_TXWAIT,
    ST_RXPUT,
    ST_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {
    K_OUT,
    K_DUMMY,
    K_WR,
    K_RD
  } item_kind_e;

  // line code 3 is treated as four lines
  function automatic logic [1:0] pad_to_log(input logic [1:0] pad);
    return (pad == 2'd3) ? 2'd2 : pad;
  endfunction

endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table
  import flash_seq_pkg::*;
#(
  parameter int SEQS  = 16,
  parameter int WORDS = 4,
  localparam int SEQ_W  = $clog2(SEQS),
  localparam int SLOT_W = $clog2(WORDS * 2),
  localparam int WIDX_W = $clog2(SEQS * WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [SEQ_W-1:0]  rd_seq,
  input  logic [SLOT_W-1:0] rd_slot,
  output instr_t            rd_instr
);

  logic [31:0] mem [SEQS*WORDS];
  logic [31:0] word;
  logic [15:0] half [2];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign word = mem[{rd_seq, rd_slot[SLOT_W-1:1]}];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half[h] = word[16*h +: 16];
  end

  assign rd_instr = half[rd_slot[0]];

endmodule

// File: rtl/flash_seq_lanes.sv
module flash_seq_lanes (
  input  logic [3:0] sh_top,
  input  logic [1:0] llog,
  input  logic       drive,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic [3:0] in_bits
);

  logic [3:0] mask;

  always_comb begin
    case (llog)
      2'd0: begin
        io_out  = {3'b000, sh_top[3]};
        in_bits = {3'b000, io_in[1]};
        mask    = 4'b0001;
      end
      2'd1: begin
        io_out  = {2'b00, sh_top[3:2]};
        in_bits = {2'b00, io_in[1:0]};
        mask    = 4'b0011;
      end
      default: begin
        io_out  = sh_top;
        in_bits = io_in;
        mask    = 4'b1111;
      end
    endcase
  end

  assign io_oe = drive ? mask : 4'b0000;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEQ_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [CNT_W-1:0]  trig_cnt,
  input  logic [SEQ_W-1:0]  trig_seq,
  input  logic [31:0]       addr_value,
  input  instr_t            instr,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  input  logic              rx_ready,
  input  logic [3:0]        in_bits,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        sh_top,
  output logic [1:0]        llog,
  output logic              drive,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(2 ** SLOT_W - 1);
  localparam logic [6:0] DCAP = 7'(DUMMY_CAP);
  localparam logic [5:0] ACAP = 6'(ADDR_CAP);

  seq_state_e        state_q, adv_state;
  item_kind_e        kind_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [SLOT_W-1:0] slot_q, adv_slot;
  logic [CNT_W-1:0]  cnt_q, bytes_q;
  logic [1:0]        llog_q, ll_dec;
  logic [6:0]        cyc_q;
  logic [31:0]       sh_q, sh_next;
  logic              sclk_q, csn_q;
  logic [2:0]        lanes_n;
  logic [5:0]        abits;
  logic [6:0]        a_cyc, d_cyc, b_cyc_dec, b_cyc_q;

  // decode of the instruction in the current slot
  assign ll_dec    = pad_to_log(instr.pad);
  assign abits     = (instr.opnd > 8'(ADDR_CAP)) ? ACAP : instr.opnd[5:0];
  assign a_cyc     = {1'b0, abits} >> ll_dec;
  assign d_cyc     = (instr.opnd > 8'(DUMMY_CAP)) ? DCAP : instr.opnd[6:0];
  assign b_cyc_dec = 7'd8 >> ll_dec;
  assign b_cyc_q   = 7'd8 >> llog_q;

  assign lanes_n = 3'd1 << llog_q;
  assign sh_next = (kind_q == K_RD) ? ((sh_q << lanes_n) | {28'd0, in_bits})
                                    : (sh_q << lanes_n);

  // where the sequence goes after the current slot is done
  always_comb begin
    if (slot_q == SLOT_LAST) begin
      adv_state = ST_FINISH;
      adv_slot  = slot_q;
    end else begin
      adv_state = ST_LOAD;
      adv_slot  = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_OUT;
      seq_q   <= '0;
      slot_q  <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
      llog_q  <= 2'd0;
      cyc_q   <= '0;
      sh_q    <= '0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (trig_valid) begin
            seq_q   <= trig_seq;
            cnt_q   <= trig_cnt;
            slot_q  <= '0;
            csn_q   <= 1'b0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          llog_q <= ll_dec;
          case (instr.opc)
            OPC_STOP: state_q <= ST_FINISH;
            OPC_CMD, OPC_MODE: begin
              sh_q    <= {instr.opnd, 24'd0};
              cyc_q   <= b_cyc_dec;
              kind_q  <= K_OUT;
              state_q <= ST_SHIFT;
            end
            OPC_ADDR: begin
              if (a_cyc == 7'd0) begin
                state_q <= adv_state;
                slot_q  <= adv_slot;
              end else begin
                sh_q    <= addr_value << (7'd32 - {1'b0, abits});
                cyc_q   <= a_cyc;
                kind_q  <= K_OUT;
                state_q <= ST_SHIFT;
              end
            end
            OPC_DUMMY: begin
              if (d_cyc == 7'd0) begin
                state_q <= adv_state;
                slot_q  <= adv_slot;
              end else begin
                cyc_q   <= d_cyc;
                kind_q  <= K_DUMMY;
                state_q <= ST_SHIFT;
              end
            end
            OPC_WRITE, OPC_READ: begin
              if (cnt_q == '0) begin
                state_q <= adv_state;
                slot_q  <= adv_slot;
              end else begin
                bytes_q <= cnt_q;
                cyc_q   <= b_cyc_dec;
                if (instr.opc == OPC_WRITE) begin
                  kind_q  <= K_WR;
                  state_q <= ST_TXWAIT;
                end else begin
                  kind_q  <= K_RD;
                  state_q <= ST_SHIFT;
                end
              end
            end
            default: begin
              state_q <= adv_state;
              slot_q  <= adv_slot;
            end
          endcase
        end
        ST_TXWAIT: begin
          if (tx_valid) begin
            sh_q    <= {tx_data, 24'd0};
            cyc_q   <= b_cyc_q;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (kind_q != K_DUMMY) sh_q <= sh_next;
            if (cyc_q == 7'd1) begin
              if (kind_q == K_RD) begin
                state_q <= ST_RXPUT;
              end else if (kind_q == K_WR && bytes_q != CNT_W'(1)) begin
                bytes_q <= bytes_q - 1'b1;
                state_q <= ST_TXWAIT;
              end else begin
                state_q <= adv_state;
                slot_q  <= adv_slot;
              end
            end else begin
              cyc_q <= cyc_q - 1'b1;
            end
          end
        end
        ST_RXPUT: begin
          if (rx_ready) begin
            if (bytes_q == CNT_W'(1)) begin
              state_q <= adv_state;
              slot_q  <= adv_slot;
            end else begin
              bytes_q <= bytes_q - 1'b1;
              cyc_q   <= b_cyc_q;
              state_q <= ST_SHIFT;
            end
          end
        end
        ST_FINISH: begin
          csn_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_seq   = seq_q;
  assign rd_slot  = slot_q;
  assign busy     = (state_q != ST_IDLE);
  assign cs_n     = csn_q;
  assign sclk     = sclk_q;
  assign sh_top   = sh_q[31:28];
  assign llog     = llog_q;
  assign drive    = (state_q == ST_SHIFT) && (kind_q == K_OUT || kind_q == K_WR);
  assign tx_ready = (state_q == ST_TXWAIT);
  assign rx_valid = (state_q == ST_RXPUT);
  assign rx_data  = sh_q[7:0];

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SEQS    = 16,
  parameter int WORDS   = 4,
  parameter int SEQ_LSB = 24,
  localparam int SEQ_W  = $clog2(SEQS),
  localparam int SLOT_W = $clog2(WORDS * 2),
  localparam int WIDX_W = $clog2(SEQS * WORDS),
  localparam int TBL_AW = WIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_addr,
  input  logic [31:0]       tbl_wdata,
  input  logic              trig_we,
  input  logic [31:0]       trig_word,
  input  logic [31:0]       addr_value,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [7:0]        tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [7:0]        rx_data
);

  instr_t            cur_instr;
  logic [SEQ_W-1:0]  rd_seq;
  logic [SLOT_W-1:0] rd_slot;
  logic [3:0]        sh_top, in_bits;
  logic [1:0]        llog;
  logic              drive;
  logic              unused_bits;

  assign unused_bits = ^{tbl_addr[1:0], trig_word};

  flash_seq_table #(.SEQS(SEQS), .WORDS(WORDS)) u_table (
    .clk      (clk),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_addr[TBL_AW-1:2]),
    .wr_data  (tbl_wdata),
    .rd_seq   (rd_seq),
    .rd_slot  (rd_slot),
    .rd_instr (cur_instr)
  );

  flash_seq_ctrl #(.CNT_W(CNT_W), .SEQ_W(SEQ_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_we),
    .trig_cnt   (trig_word[CNT_W-1:0]),
    .trig_seq   (trig_word[SEQ_LSB +: SEQ_W]),
    .addr_value (addr_value),
    .instr      (cur_instr),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .rx_ready   (rx_ready),
    .in_bits    (in_bits),
    .rd_seq     (rd_seq),
    .rd_slot    (rd_slot),
    .busy       (busy),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .sh_top     (sh_top),
    .llog       (llog),
    .drive      (drive),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data)
  );

  flash_seq_lanes u_lanes (
    .sh_top  (sh_top),
    .llog    (llog),
    .drive   (drive),
    .io_in   (io_in),
    .io_out  (io_out),
    .io_oe   (io_oe),
    .in_bits (in_bits)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);

  // R10
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && io_oe == 4'b0000));

  // R8
  sclk_single_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);

  // R8
  sclk_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R6
  tx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> (tx_ready && !sclk));

  // R6
  streams_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && rx_valid));

endmodule

bind flash_seq_engine flash_seq_chk u_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .io_oe    (io_oe),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data)
);

// File: tb/test_flash_seq_engine.sv
module test_flash_seq_engine;

  typedef struct packed {
    logic [3:0] seq;
    logic [7:0] cmd;
    logic [1:0] cpad;
    logic [5:0] abits;
    logic [1:0] apad;
    logic [7:0] dummy;
    logic [1:0] dir;   // 0 none, 1 write, 2 read
    logic [1:0] dpad;
    logic [7:0] cnt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  8'h9F, 2'd0, 6'd0,  2'd0, 8'd0, 2'd2, 2'd0, 8'd3},
    '{4'd15, 8'h02, 2'd0, 6'd24, 2'd0, 8'd0, 2'd1, 2'd0, 8'd4},
    '{4'd7,  8'h6B, 2'd0, 6'd24, 2'd0, 8'd8, 2'd2, 2'd1, 8'd5},
    '{4'd1,  8'hEB, 2'd0, 6'd32, 2'd2, 8'd6, 2'd2, 2'd2, 8'd4},
    '{4'd0,  8'h38, 2'd0, 6'd24, 2'd2, 8'd0, 2'd1, 2'd2, 8'd3},
    '{4'd9,  8'h06, 2'd0, 6'd0,  2'd0, 8'd0, 2'd0, 2'd0, 8'd7},
    '{4'd4,  8'h3B, 2'd1, 6'd24, 2'd1, 8'd8, 2'd2, 2'd1, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        trig_we = 1'b0;
  logic [31:0] trig_word = '0;
  logic [31:0] addr_value = '0;
  logic        busy, cs_n, sclk, tx_ready, rx_valid;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;

  flash_seq_engine i_flash_seq_engine (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .trig_we(trig_we), .trig_word(trig_word),
    .addr_value(addr_value), .busy(busy), .cs_n(cs_n), .sclk(sclk),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  initial forever #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // flash-side monitor state
  logic [3:0] m_out [1024];
  logic [3:0] m_oe  [1024];
  logic [7:0] rx_got [64];
  int ncyc = 0, tx_idx = 0, rx_n = 0, neg_cnt = 0, cur_cnt = 0;
  bit pend_tx = 1'b0, prev_sclk = 1'b0;
  logic [3:0] prev_out = '0;

  function automatic logic [3:0] rdpat(input int n);
    return 4'((n * 7 + 5) ^ (n >> 2));
  endfunction

  function automatic logic [7:0] txpat(input int k);
    return 8'(8'h3C + k * 29);
  endfunction

  initial forever begin
    @(negedge clk);
    neg_cnt++;
    if (sclk) begin
      chk(!prev_sclk, "R8 high phase longer than one clock", 1, 0);
      chk(io_out == prev_out, "R8 io_out changed at rising sclk", io_out, prev_out);
      if (ncyc < 1024) begin
        m_out[ncyc] = io_out;
        m_oe[ncyc]  = io_oe;
      end
      io_in = rdpat(ncyc);
      ncyc++;
    end
    prev_sclk = sclk;
    prev_out  = io_out;
    if (pend_tx) tx_idx++;
    tx_valid = (tx_idx < cur_cnt) && (neg_cnt % 3 != 0);
    tx_data  = txpat(tx_idx);
    pend_tx  = tx_valid && tx_ready;
    rx_ready = (neg_cnt % 4 != 1);
    if (rx_valid && rx_ready) begin
      if (rx_n < 64) rx_got[rx_n] = rx_data;
      rx_n++;
    end
  end

  function automatic logic [31:0] dec_out(input int start, input int n, input logic [1:0] pad);
    logic [31:0] v = '0;
    for (int c = 0; c < n; c++) begin
      if (start + c < 1024) begin
        case (pad)
          2'd0:    v = {v[30:0], m_out[start+c][0]};
          2'd1:    v = {v[29:0], m_out[start+c][1:0]};
          default: v = {v[27:0], m_out[start+c]};
        endcase
      end
    end
    return v;
  endfunction

  function automatic bit oe_all(input int start, input int n, input logic [3:0] mask);
    bit ok = 1'b1;
    for (int c = 0; c < n; c++) begin
      if (start + c >= 1024 || m_oe[start+c] != mask) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [7:0] rd_exp(input int start, input logic [1:0] pad);
    logic [7:0] v = '0;
    int n = 8 >> pad;
    for (int c = 0; c < n; c++) begin
      logic [3:0] p = rdpat(start + c);
      case (pad)
        2'd0:    v = {v[6:0], p[1]};
        2'd1:    v = {v[5:0], p[1:0]};
        default: v = {v[3:0], p};
      endcase
    end
    return v;
  endfunction

  function automatic logic [3:0] pmask(input logic [1:0] pad);
    return (pad == 2'd0) ? 4'b0001 : (pad == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic write_seq(input logic [3:0] seq, input logic [15:0] ins [8]);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      tbl_we    = 1'b1;
      tbl_addr  = {seq, 2'(w), 2'b00};
      tbl_wdata = {ins[2*w+1], ins[2*w]};
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic start_txn(input logic [3:0] seq, input int cnt);
    @(posedge clk);
    ncyc = 0; tx_idx = 0; rx_n = 0; pend_tx = 1'b0; cur_cnt = cnt;
    @(negedge clk);
    trig_we   = 1'b1;
    trig_word = {4'd0, seq, 8'd0, 16'(cnt)};
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  task automatic pulse_trig(input logic [3:0] seq, input int cnt);
    @(negedge clk);
    trig_we   = 1'b1;
    trig_word = {4'd0, seq, 8'd0, 16'(cnt)};
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] ins [8];
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 cs_n/sclk in reset", {cs_n, sclk}, 2'b10);
    chk(busy == 1'b0 && io_oe == 4'd0, "R1 busy/io_oe in reset", {busy, io_oe}, 0);
    chk(tx_ready == 1'b0 && rx_valid == 1'b0, "R1 streams in reset", {tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && sclk == 1'b0, "R1 state after reset", {cs_n, busy, sclk}, 3'b100);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      int k, cc, ac, dc, bc, total, base;
      logic [31:0] av, aexp;
      t = VECS[v];
      for (int i = 0; i < 8; i++) ins[i] = 16'h0000;
      k = 0;
      ins[k] = {6'd1, t.cpad, t.cmd}; k++;
      if (t.abits != 0) begin ins[k] = {6'd2, t.apad, 2'b00, t.abits}; k++; end
      if (t.dummy != 0) begin ins[k] = {6'd3, 2'd0, t.dummy}; k++; end
      if (t.dir == 2'd1) begin ins[k] = {6'd8, t.dpad, 8'd0}; k++; end
      if (t.dir == 2'd2) begin ins[k] = {6'd7, t.dpad, 8'd0}; k++; end
      av = 32'hC3A5_0F96 + 32'(v) * 32'h0102_0304;
      addr_value = av;
      write_seq(t.seq, ins);
      start_txn(t.seq, int'(t.cnt));
      wait_idle();
      cc = 8 >> t.cpad;
      ac = int'(t.abits) >> t.apad;
      dc = int'(t.dummy);
      bc = 8 >> t.dpad;
      total = cc + ac + dc + ((t.dir != 0) ? int'(t.cnt) * bc : 0);
      chk(ncyc == total, "R2 serial cycle count", ncyc, total);
      chk(cs_n == 1'b1, "R10 cs_n high after stop", cs_n, 1);
      chk(dec_out(0, cc, t.cpad) == {24'd0, t.cmd}, "R3 command bits", dec_out(0, cc, t.cpad), t.cmd);
      chk(oe_all(0, cc, pmask(t.cpad)), "R3 command enables", 0, pmask(t.cpad));
      if (t.abits != 0) begin
        aexp = (t.abits == 6'd32) ? av : (av & ((32'd1 << t.abits) - 32'd1));
        chk(dec_out(cc, ac, t.apad) == aexp, "R4 address bits", dec_out(cc, ac, t.apad), aexp);
      end
      if (t.dummy != 0)
        chk(oe_all(cc + ac, dc, 4'b0000), "R5 dummy lines released", 1, 0);
      base = cc + ac + dc;
      if (t.dir == 2'd1) begin
        chk(tx_idx == int'(t.cnt), "R6 bytes taken from tx", tx_idx, t.cnt);
        for (int b = 0; b < int'(t.cnt); b++)
          chk(dec_out(base + b * bc, bc, t.dpad) == {24'd0, txpat(b)}, "R6 write byte",
              dec_out(base + b * bc, bc, t.dpad), txpat(b));
        chk(oe_all(base, int'(t.cnt) * bc, pmask(t.dpad)), "R6 write enables", 0, pmask(t.dpad));
      end
      if (t.dir == 2'd2) begin
        chk(rx_n == int'(t.cnt), "R7 bytes returned on rx", rx_n, t.cnt);
        for (int b = 0; b < int'(t.cnt) && b < rx_n; b++)
          chk(rx_got[b] == rd_exp(base + b * bc, t.dpad), "R7 read byte",
              rx_got[b], rd_exp(base + b * bc, t.dpad));
      end
      if (t.dir == 2'd0)
        chk(tx_idx == 0 && rx_n == 0, "R9 count unused without data slot", tx_idx + rx_n, 0);
    end

    // R10 / R3: no stop, slot 7 ends; mode opcode; unknown opcodes skipped
    ins[0] = {6'd1, 2'd2, 8'hA5};
    ins[1] = {6'd4, 2'd1, 8'h5A};
    for (int i = 2; i < 8; i++) ins[i] = {6'd5, 2'd0, 8'hFF};
    write_seq(4'd5, ins);
    start_txn(4'd5, 0);
    wait_idle();
    chk(ncyc == 6, "R10 run-out sequence cycles", ncyc, 6);
    chk(dec_out(0, 2, 2'd2) == 32'hA5, "R3 quad command", dec_out(0, 2, 2'd2), 32'hA5);
    chk(dec_out(2, 4, 2'd1) == 32'h5A, "R3 dual mode byte", dec_out(2, 4, 2'd1), 32'h5A);
    chk(cs_n == 1'b1, "R10 cs_n after slot 7", cs_n, 1);

    // R5: dummy cap
    for (int i = 0; i < 8; i++) ins[i] = 16'h0000;
    ins[0] = {6'd3, 2'd0, 8'd200};
    write_seq(4'd6, ins);
    start_txn(4'd6, 0);
    wait_idle();
    chk(ncyc == 64, "R5 dummy capped at 64", ncyc, 64);
    chk(oe_all(0, 64, 4'b0000), "R5 capped dummy lines released", 1, 0);

    // R9: trigger while busy ignored
    ins[0] = {6'd3, 2'd0, 8'd20};
    write_seq(4'd8, ins);
    ins[0] = {6'd1, 2'd0, 8'hFF};
    write_seq(4'd10, ins);
    start_txn(4'd8, 0);
    chk(busy == 1'b1, "R9 busy after trigger", busy, 1);
    repeat (6) @(negedge clk);
    pulse_trig(4'd10, 0);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(ncyc == 20 && busy == 1'b0, "R9 trigger while busy ignored", ncyc, 20);

    // R7: zero byte count skips the read
    ins[0] = {6'd1, 2'd0, 8'h03};
    ins[1] = {6'd7, 2'd0, 8'd0};
    write_seq(4'd11, ins);
    start_txn(4'd11, 0);
    wait_idle();
    chk(ncyc == 8 && rx_n == 0, "R7 zero-count read skipped", ncyc + rx_n, 8);

    // R10: stop in slot 0
    for (int i = 0; i < 8; i++) ins[i] = 16'h0000;
    write_seq(4'd12, ins);
    start_txn(4'd12, 0);
    chk(busy == 1'b1 && cs_n == 1'b0, "R10 select during empty sequence", {busy, cs_n}, 2'b10);
    wait_idle();
    chk(ncyc == 0 && cs_n == 1'b1, "R10 stop in slot 0", ncyc, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule